// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps two independent 64-bit up-counting time bases: a main one and an alternate one. It also keeps a 32-bit down-counting decrementer that requests an exception. One tick-enable input clocks all three counters. A run input can freeze both time bases together without losing their contents. The decrementer does not use the run input and counts on every tick.

Software reaches the counters through a small register port. Each time base is split into a lower and an upper 32-bit half, and each half is written or read on its own. The decrementer is a single 32-bit register. A real-time-clock mode restricts the main time base's lower half to the bits chosen by a mask parameter. A reload pulse sets the decrementer to all ones without raising a request; it is used at start-up and when the tick frequency changes. The exception request is sticky and is released by a clear pulse.

Top module: `tbdec_unit`

## Requirements
- R1: Writing a lower half of a time base leaves its upper half unchanged, and writing an upper half leaves its lower half unchanged. A write to a time base takes priority over a tick in the same cycle.
- R2: The main and alternate time bases are separate registers. Select codes: 0 = main lower, 1 = main upper, 2 = alternate lower, 3 = alternate upper, 4 = decrementer. A write to one time base does not change the other.
- R3: While run is high, each tick adds one to both 64-bit time bases, and a carry passes from the lower half into the upper half.
- R4: While run is low, both time bases hold their values. When run returns high, counting resumes from the held values.
- R5: The decrementer decreases by one on every tick, whatever the state of run. A software write in the same cycle as a tick takes priority over the tick.
- R6: A software write to the decrementer sets the exception request only when bit 31 of the new value is 1 and bit 31 of the old value is 0.
- R7: A tick while the decrementer holds zero sets the exception request and leaves the decrementer at 0xFFFFFFFF.
- R8: A reload pulse loads the decrementer with 0xFFFFFFFF and raises no request. Reload takes priority over a write or a tick in the same cycle.
- R9: With rtc_mode high, writes to the main lower half store only the bits of mask 0x3FFFFF80, and reads of that half return only those bits. The alternate time base is not affected by rtc_mode.
- R10: The exception request stays set until exc_clr is pulsed. If a set and a clear happen in the same cycle, the set wins.
- R11: After reset, both time bases read 0, the decrementer reads 0xFFFFFFFF and the request is low. Reads with select codes 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for all counters |
| tb_run | input | 1 | High lets both time bases count |
| rtc_mode | input | 1 | Masks the main lower half |
| reload | input | 1 | Loads the decrementer with all ones |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register written |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register read |
| rd_data | output | 32 | Read data (combinational) |
| exc_clr | input | 1 | Clears the exception request |
| exc_req | output | 1 | Sticky decrementer exception request |

## Verification
The bound checker watches every cycle. It checks that both time bases hold while run is low, that they step by one under a tick, that a half write preserves the other half, that a wrap or a reload leaves the decrementer at all ones, and that the request stays set until cleared. Some behaviour shows only in the bench's scenarios, because it needs values observed through the read port: masked storage in real-time-clock mode, a carry into the upper half, the old-sign condition on software writes, and the priority of reload over a simultaneous write and tick.

// File: rtl/tbdec_unit.sv
module tbdec_unit #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RTC_MASK = 'h3FFFFF80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         tb_run,
  input  logic         rtc_mode,
  input  logic         reload,
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_sel,
  output logic [W-1:0] rd_data,
  input  logic         exc_clr,
  output logic         exc_req
);
  localparam logic [2:0] S_MLO = 3'd0, S_MHI = 3'd1, S_ALO = 3'd2,
                         S_AHI = 3'd3, S_DEC = 3'd4;
  localparam int unsigned TW = 2 * W;

  logic [TW-1:0] tb_main, tb_alt;
  logic [W-1:0]  dec_q;

  wire adv    = tick & tb_run;
  wire dec_we = wr_en & (wr_sel == S_DEC);
  wire [W-1:0] mlo_wdata = rtc_mode ? (wr_data & RTC_MASK) : wr_data;

  function automatic logic [TW-1:0] tb_next(input logic [TW-1:0] cur,
      input logic lo_we, input logic hi_we, input logic [W-1:0] d,
      input logic step);
    if (lo_we)      return {cur[TW-1:W], d};
    else if (hi_we) return {d, cur[W-1:0]};
    else if (step)  return cur + 1'b1;
    else            return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tb_main <= '0;
      tb_alt  <= '0;
    end else begin
      tb_main <= tb_next(tb_main, wr_en && wr_sel == S_MLO,
                         wr_en && wr_sel == S_MHI,
                         (wr_sel == S_MLO) ? mlo_wdata : wr_data, adv);
      tb_alt  <= tb_next(tb_alt, wr_en && wr_sel == S_ALO,
                         wr_en && wr_sel == S_AHI, wr_data, adv);
    end
  end

  wire exc_set = !reload &&
                 ((dec_we && wr_data[W-1] && !dec_q[W-1]) ||
                  (!dec_we && tick && dec_q == '0));

  always_ff @(posedge clk) begin
    if (!rst_n)      dec_q <= '1;
    else if (reload) dec_q <= '1;
    else if (dec_we) dec_q <= wr_data;
    else if (tick)   dec_q <= dec_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       exc_req <= 1'b0;
    else if (exc_set) exc_req <= 1'b1;
    else if (exc_clr) exc_req <= 1'b0;
  end

  always_comb begin
    case (rd_sel)
      S_MLO:   rd_data = rtc_mode ? (tb_main[W-1:0] & RTC_MASK) : tb_main[W-1:0];
      S_MHI:   rd_data = tb_main[TW-1:W];
      S_ALO:   rd_data = tb_alt[W-1:0];
      S_AHI:   rd_data = tb_alt[TW-1:W];
      S_DEC:   rd_data = dec_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tbdec_unit_chk.sv
module tbdec_unit_chk #(
  parameter int unsigned W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick,
  input logic            tb_run,
  input logic            reload,
  input logic            wr_en,
  input logic [2:0]      wr_sel,
  input logic [W-1:0]    wr_data,
  input logic            exc_clr,
  input logic            exc_req,
  input logic [2*W-1:0]  tb_main,
  input logic [2*W-1:0]  tb_alt,
  input logic [W-1:0]    dec_q
);
  a_r1_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=> tb_main[2*W-1:W] == $past(tb_main[2*W-1:W]));

  a_r1_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd3) |=> tb_alt[W-1:0] == $past(tb_alt[W-1:0]));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_run && tick && !wr_en) |=> tb_main == $past(tb_main) + 1'b1);

  a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_run && !wr_en) |=> ($stable(tb_main) && $stable(tb_alt)));

  a_r6_sign_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && wr_en && wr_sel == 3'd4 && wr_data[W-1] && !dec_q[W-1]) |=> exc_req);

  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !(wr_en && wr_sel == 3'd4) && tick && dec_q == '0)
      |=> (exc_req && dec_q == '1));

  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> dec_q == '1);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && !exc_clr) |=> exc_req);
endmodule

bind tbdec_unit tbdec_unit_chk #(.W(W)) u_chk (.*);

// File: tb/tb_tbdec_unit.sv
module tb_tbdec_unit;
  logic clk = 1'b0;
  logic rst_n, tick, tb_run, rtc_mode, reload, wr_en, exc_clr;
  logic [2:0] wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic exc_req;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  tbdec_unit dut (.clk(clk), .rst_n(rst_n), .tick(tick), .tb_run(tb_run),
    .rtc_mode(rtc_mode), .reload(reload), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .exc_clr(exc_clr), .exc_req(exc_req));

  // {sel, data, rtc_mode, expected readback}
  localparam logic [67:0] VEC [0:6] = '{
    {3'd0, 32'h12345678, 1'b0, 32'h12345678},
    {3'd1, 32'hDEADBEEF, 1'b0, 32'hDEADBEEF},
    {3'd2, 32'h0000AAAA, 1'b0, 32'h0000AAAA},
    {3'd3, 32'h00005555, 1'b0, 32'h00005555},
    {3'd2, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF},
    {3'd0, 32'hFFFFFFFF, 1'b1, 32'h3FFFFF80},
    {3'd4, 32'h00001000, 1'b0, 32'h00001000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [2:0] sel, input logic [31:0] exp);
    rd_sel = sel;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic op(input logic [2:0] sel, input logic wr, input logic [31:0] d,
                    input logic tk, input logic rl, input logic cl);
    @(negedge clk);
    wr_sel = sel; wr_en = wr; wr_data = d; tick = tk; reload = rl; exc_clr = cl;
    @(negedge clk);
    wr_en = 0; tick = 0; reload = 0; exc_clr = 0;
  endtask

  task automatic reset_checks();
    rd("R11 main lo", 3'd0, 32'h0);
    rd("R11 main hi", 3'd1, 32'h0);
    rd("R11 alt lo", 3'd2, 32'h0);
    rd("R11 alt hi", 3'd3, 32'h0);
    rd("R11 dec", 3'd4, 32'hFFFFFFFF);
    rd("R11 unused sel", 3'd5, 32'h0);
    chk("R11 exc", {31'b0, exc_req}, 32'h0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; tick = 0; tb_run = 0; rtc_mode = 0; reload = 0; wr_en = 0;
    exc_clr = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    reset_checks();

    for (int i = 0; i < 7; i++) begin
      rtc_mode = VEC[i][32];
      op(VEC[i][67:65], 1'b1, VEC[i][64:33], 1'b0, 1'b0, 1'b0);
      rd("table R1 R2 R9", VEC[i][67:65], VEC[i][31:0]);
    end
    rtc_mode = 0;
    rd("R9 stored masked", 3'd0, 32'h3FFFFF80);
    rd("R1 main hi kept", 3'd1, 32'hDEADBEEF);
    rd("R2 alt hi separate", 3'd3, 32'h00005555);
    chk("R6 no set, old sign set", {31'b0, exc_req}, 32'h0);

    tb_run = 1;
    op(3'd0, 0, 0, 1, 0, 0);
    rd("R3 carry lo", 3'd2, 32'h0);
    rd("R3 carry hi", 3'd3, 32'h00005556);
    rd("R3 main step", 3'd0, 32'h3FFFFF81);
    rd("R5 dec step", 3'd4, 32'h00000FFF);

    tb_run = 0;
    repeat (3) op(3'd0, 0, 0, 1, 0, 0);
    rd("R4 main held", 3'd0, 32'h3FFFFF81);
    rd("R4 alt held", 3'd2, 32'h0);
    rd("R5 dec ignores run", 3'd4, 32'h00000FFC);
    tb_run = 1;
    repeat (2) op(3'd0, 0, 0, 1, 0, 0);
    rd("R4 resume", 3'd0, 32'h3FFFFF83);
    rd("R4 alt resume", 3'd2, 32'h2);

    op(3'd0, 1, 32'h100, 1, 0, 0);
    rd("R1 write beats tick", 3'd0, 32'h100);
    rd("R1 hi kept", 3'd1, 32'hDEADBEEF);
    rd("R2 alt still ticks", 3'd2, 32'h3);
    op(3'd4, 1, 32'h50, 1, 0, 0);
    rd("R5 write beats tick", 3'd4, 32'h50);
    tb_run = 0;

    op(3'd4, 1, 32'h80000000, 0, 0, 0);
    chk("R6 sign change sets", {31'b0, exc_req}, 32'h1);
    op(3'd0, 0, 0, 0, 0, 0);
    chk("R10 sticky", {31'b0, exc_req}, 32'h1);
    op(3'd0, 0, 0, 0, 0, 1);
    chk("R10 cleared", {31'b0, exc_req}, 32'h0);

    op(3'd4, 1, 32'h1, 0, 0, 0);
    chk("R6 positive write no set", {31'b0, exc_req}, 32'h0);
    op(3'd0, 0, 0, 1, 0, 0);
    rd("R7 reach zero", 3'd4, 32'h0);
    chk("R7 no set at zero", {31'b0, exc_req}, 32'h0);
    op(3'd0, 0, 0, 1, 0, 0);
    rd("R7 wrap value", 3'd4, 32'hFFFFFFFF);
    chk("R7 wrap sets", {31'b0, exc_req}, 32'h1);
    op(3'd0, 0, 0, 0, 0, 1);

    op(3'd4, 1, 32'h5, 0, 0, 0);
    op(3'd4, 1, 32'h80000000, 1, 1, 0);
    rd("R8 reload wins", 3'd4, 32'hFFFFFFFF);
    chk("R8 no request", {31'b0, exc_req}, 32'h0);

    op(3'd4, 1, 32'h0, 0, 0, 0);
    chk("R6 no set to zero", {31'b0, exc_req}, 32'h0);
    op(3'd0, 0, 0, 1, 0, 1);
    chk("R10 set beats clear", {31'b0, exc_req}, 32'h1);
    rd("R7 wrap under clear", 3'd4, 32'hFFFFFFFF);

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    reset_checks();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule